// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Engine

This block refills one 16-word line of a direct-mapped cache after a miss. A miss arrives as a line address and the offset of the word the CPU needs. The engine asks memory for that word first. It then asks for the other fifteen words in rising offset order, wrapping from offset 15 back to offset 0. Every word that comes back is written into the data array at its true position in the line. The first word returned is also handed to the CPU together with a one-cycle restart pulse, so the CPU can carry on while the rest of the line is still arriving.

Once all sixteen words are in the array, the engine writes the tag and the valid flag for the line. Before that the valid flag stays clear. A probe input reports a stall for any access to the line being filled. Every memory request gets exactly one response, and responses come back in the order the requests were issued.

The miss port, the memory request port and the memory response port use valid/ready handshakes. A transfer takes place on a clock edge where both valid and ready are high. The miss port is ready only while the engine is idle. A blocked memory request keeps its valid high and its address unchanged until memory accepts it. Memory may hold back a response for any number of cycles. The engine raises response ready only while it still expects words. The array write, tag update, restart and probe signals are plain signals with no handshake.

Top module: `cwf_refill_engine`

## Requirements
- R1: The first memory request after a miss is accepted carries the missed line address and the missed word offset.
- R2: Exactly 16 requests are issued per fill. Each request after the first has a word offset one higher than the one before, modulo 16, so offset 15 is followed by offset 0.
- R3: A memory request address is {line address, 4-bit word offset}, with the offset in the low 4 bits. Every request of a fill carries the missed line address.
- R4: cpu_restart rises in the cycle after the first response is accepted, before the last word of the line is written. In that cycle cpu_data equals the data of that first response.
- R5: tag_we pulses exactly once, in the cycle after the 16th response is accepted. In that cycle tag_index is line[IDX_W-1:0], tag_value is the upper TAG_W bits of the line, and tag_valid is 1. busy is low in the following cycle.
- R6: Each accepted response is written in the same cycle (arr_we high), at arr_index equal to the low line bits and at arr_word equal to the word's own offset, whatever its arrival order.
- R7: The tag update comes only after all 16 words have been written. probe_stall is high from the cycle after the miss is accepted through the tag update cycle when probe_line equals the line being filled. It is low otherwise.
- R8: While a fill is in progress miss_ready is low. A miss request presented during the fill is not accepted and does not change the fill.
- R9: cpu_restart is high for a single cycle per fill.
- R10: A memory request that is not accepted stays valid with an unchanged address in the next cycle.
- R11: After reset busy, mreq_valid, arr_we, tag_we and cpu_restart are low and miss_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Engine idle, miss can be taken |
| miss_line | input | TAG_W+IDX_W | Line address of the miss |
| miss_word | input | OFS_W | Offset of the needed word |
| busy | output | 1 | Fill in progress |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_addr | output | TAG_W+IDX_W+OFS_W | Word address requested |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Engine accepts response |
| mrsp_data | input | WORD_W | Response data |
| arr_we | output | 1 | Data array write strobe |
| arr_index | output | IDX_W | Array line index |
| arr_word | output | OFS_W | Word position in line |
| arr_wdata | output | WORD_W | Word written |
| tag_we | output | 1 | Tag/valid update strobe |
| tag_index | output | IDX_W | Line index for the tag update |
| tag_value | output | TAG_W | Tag written |
| tag_valid | output | 1 | Valid flag written |
| cpu_restart | output | 1 | Early restart pulse |
| cpu_data | output | WORD_W | Requested word for the CPU |
| probe_line | input | TAG_W+IDX_W | Line of a new CPU access |
| probe_stall | output | 1 | New access must wait |

## Verification
Two pairs of events can fall in the same clock cycle. In the first, the engine issues a later request while memory returns the critical word, so the restart path and the array write run alongside request issue. The bench provokes this by holding request ready high while responses come back one cycle after their requests. It then judges the full request order, the position of every array write, and the restart data and timing. In the second, a competing miss is held valid for a whole fill, so it is present in the same cycle as the tag update. The bench checks that this miss is never accepted and that the tag fields and busy drop belong to the original line. Irregular ready and valid masks also make requests wait while responses arrive, and the other way round.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_t;
endpackage

// File: rtl/cwf_seq.sv
// Offset sequencer: counts transfers of one fill and yields base+count mod line size.
module cwf_seq #(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [OFS_W-1:0] base,
  output logic [OFS_W-1:0] idx,
  output logic             done
);
  logic [OFS_W:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (step && !done)   cnt <= cnt + 1'b1;
  end

  assign idx  = base + cnt[OFS_W-1:0];
  assign done = cnt[OFS_W];
endmodule

// File: rtl/cwf_restart.sv
// Registers the critical word and produces the one-cycle early restart pulse.
module cwf_restart #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word_in,
  output logic              pulse,
  output logic [WORD_W-1:0] word_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse    <= 1'b0;
      word_out <= '0;
    end else begin
      pulse <= fire;
      if (fire) word_out <= word_in;
    end
  end
endmodule

// File: rtl/cwf_line_match.sv
// Flags an access that targets the line currently being refilled.
module cwf_line_match #(
  parameter int LINE_W = 26
) (
  input  logic              active,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [LINE_W-1:0] access_line,
  output logic              hit
);
  assign hit = active && (fill_line == access_line);
endmodule

// File: rtl/cwf_refill_engine.sv
module cwf_refill_engine
  import cwf_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 18,
  parameter int OFS_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [TAG_W+IDX_W-1:0] miss_line,
  input  logic [OFS_W-1:0]       miss_word,
  output logic                   busy,
  output logic                   mreq_valid,
  input  logic                   mreq_ready,
  output logic [TAG_W+IDX_W+OFS_W-1:0] mreq_addr,
  input  logic                   mrsp_valid,
  output logic                   mrsp_ready,
  input  logic [WORD_W-1:0]      mrsp_data,
  output logic                   arr_we,
  output logic [IDX_W-1:0]       arr_index,
  output logic [OFS_W-1:0]       arr_word,
  output logic [WORD_W-1:0]      arr_wdata,
  output logic                   tag_we,
  output logic [IDX_W-1:0]       tag_index,
  output logic [TAG_W-1:0]       tag_value,
  output logic                   tag_valid,
  output logic                   cpu_restart,
  output logic [WORD_W-1:0]      cpu_data,
  input  logic [TAG_W+IDX_W-1:0] probe_line,
  output logic                   probe_stall
);
  localparam int LINE_W = TAG_W + IDX_W;
  localparam int NSEQ   = 2;   // 0: request side, 1: response side

  fill_state_t       state;
  logic [LINE_W-1:0] line_q;
  logic [OFS_W-1:0]  crit_q;

  logic accept, req_fire, rsp_fire, fill_end;
  logic [NSEQ-1:0]  seq_step, seq_done;
  logic [OFS_W-1:0] seq_idx [NSEQ];

  assign accept   = miss_valid && miss_ready;
  assign req_fire = mreq_valid && mreq_ready;
  assign rsp_fire = mrsp_valid && mrsp_ready;
  assign seq_step = {rsp_fire, req_fire};

  genvar g;
  generate
    for (g = 0; g < NSEQ; g++) begin : g_seq
      cwf_seq #(.OFS_W(OFS_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (seq_step[g]),
        .base  (crit_q),
        .idx   (seq_idx[g]),
        .done  (seq_done[g])
      );
    end
  endgenerate

  // All words are in once the response sequencer has counted a full line.
  assign fill_end = (state == FS_FILL) && seq_done[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      line_q <= '0;
      crit_q <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (accept) begin
          state  <= FS_FILL;
          line_q <= miss_line;
          crit_q <= miss_word;
        end
        FS_FILL: if (fill_end) state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign miss_ready = (state == FS_IDLE);
  assign busy       = (state != FS_IDLE);

  assign mreq_valid = (state == FS_FILL) && !seq_done[0];
  assign mreq_addr  = {line_q, seq_idx[0]};
  assign mrsp_ready = (state == FS_FILL) && !seq_done[1];

  assign arr_we    = rsp_fire;
  assign arr_index = line_q[IDX_W-1:0];
  assign arr_word  = seq_idx[1];
  assign arr_wdata = mrsp_data;

  assign tag_we    = fill_end;
  assign tag_valid = fill_end;
  assign tag_index = line_q[IDX_W-1:0];
  assign tag_value = line_q[LINE_W-1:IDX_W];

  cwf_restart #(.WORD_W(WORD_W)) u_restart (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (rsp_fire && (seq_idx[1] == crit_q)),
    .word_in  (mrsp_data),
    .pulse    (cpu_restart),
    .word_out (cpu_data)
  );

  cwf_line_match #(.LINE_W(LINE_W)) u_match (
    .active      (busy),
    .fill_line   (line_q),
    .access_line (probe_line),
    .hit         (probe_stall)
  );
endmodule

// File: rtl/cwf_refill_sva.sv
module cwf_refill_sva #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 18,
  parameter int OFS_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         miss_valid,
  input logic                         miss_ready,
  input logic [TAG_W+IDX_W-1:0]       miss_line,
  input logic [OFS_W-1:0]             miss_word,
  input logic                         busy,
  input logic                         mreq_valid,
  input logic                         mreq_ready,
  input logic [TAG_W+IDX_W+OFS_W-1:0] mreq_addr,
  input logic                         arr_we,
  input logic                         tag_we,
  input logic                         cpu_restart
);
  AST_FIRST_REQ_CRITICAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mreq_valid && mreq_addr == {$past(miss_line), $past(miss_word)}); // R1

  AST_REQ_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid ||
      (mreq_addr[OFS_W-1:0] == $past(mreq_addr[OFS_W-1:0]) + 1'b1)); // R2

  AST_TAG_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> $past(arr_we)); // R7

  AST_TAG_ENDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> !busy); // R5

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_restart |=> !cpu_restart); // R9

  AST_MISS_TAKEN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> busy && !miss_ready); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> mreq_valid && $stable(mreq_addr)); // R10
endmodule

bind cwf_refill_engine cwf_refill_sva #(
  .IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_W(OFS_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_line(miss_line), .miss_word(miss_word), .busy(busy),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
  .arr_we(arr_we), .tag_we(tag_we), .cpu_restart(cpu_restart)
);

// File: tb/cwf_refill_engine_tb.sv
module cwf_refill_engine_tb;
  localparam int IDX_W = 8, TAG_W = 18, OFS_W = 4, WORD_W = 32;
  localparam int LINE_W = TAG_W + IDX_W;
  localparam int MA_W = LINE_W + OFS_W;
  localparam int NVEC = 6;
  // {line, critical word, request-ready mask, response-valid mask}
  localparam logic [61:0] VEC [NVEC] = '{
    {26'h0000123, 4'd0,  16'hFFFF, 16'hFFFF},
    {26'h3FFFFFF, 4'd15, 16'hFFFF, 16'hFFFF},
    {26'h1555AAA, 4'd7,  16'hAAAA, 16'hFFFF},
    {26'h0ABCDEF, 4'd1,  16'hFFFF, 16'h5555},
    {26'h2000001, 4'd8,  16'h3333, 16'hC3C3},
    {26'h00000FF, 4'd14, 16'h0F0F, 16'h9999}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready, busy;
  logic [LINE_W-1:0] miss_line = '0, probe_line = '0;
  logic [OFS_W-1:0] miss_word = '0;
  logic mreq_valid, mreq_ready = 1'b0;
  logic [MA_W-1:0] mreq_addr;
  logic mrsp_valid = 1'b0, mrsp_ready;
  logic [WORD_W-1:0] mrsp_data = '0;
  logic arr_we, tag_we, tag_valid, cpu_restart, probe_stall;
  logic [IDX_W-1:0] arr_index, tag_index;
  logic [OFS_W-1:0] arr_word;
  logic [WORD_W-1:0] arr_wdata, cpu_data;
  logic [TAG_W-1:0] tag_value;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  cwf_refill_engine #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_W(OFS_W), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .miss_word(miss_word), .busy(busy),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .arr_we(arr_we), .arr_index(arr_index), .arr_word(arr_word), .arr_wdata(arr_wdata),
    .tag_we(tag_we), .tag_index(tag_index), .tag_value(tag_value), .tag_valid(tag_valid),
    .cpu_restart(cpu_restart), .cpu_data(cpu_data),
    .probe_line(probe_line), .probe_stall(probe_stall)
  );

  function automatic logic [WORD_W-1:0] dfun(input logic [MA_W-1:0] a);
    return {a[MA_W-1:14] ^ 16'hC0DE, a[15:0]} ^ {a[7:0], 24'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_fill(input logic [LINE_W-1:0] ln, input logic [OFS_W-1:0] wd,
                          input logic [15:0] rm, input logic [15:0] vm,
                          input bit intr, input bit pother);
    logic [MA_W-1:0] got [16];
    logic [MA_W-1:0] fq [16];
    logic [WORD_W-1:0] mem [16];
    logic [WORD_W-1:0] rdata = '0;
    logic [MA_W-1:0] prev_addr = '0;
    bit prev_wait = 0, done = 0, tag_ok = 0, ord_ok, line_ok, mem_ok;
    int cyc = 0, nreq = 0, nwr = 0, nrst = 0, rcyc = -1, lastwr = -1;
    int ntag = 0, tcyc = -1, wr_at_tag = 0, intr_acc = 0, pbad = 0, hold_bad = 0;
    int idx_bad = 0, head = 0, tail = 0;
    for (int i = 0; i < 16; i++) begin got[i] = '0; fq[i] = '0; mem[i] = '0; end
    while (!done && cyc < 400) begin
      @(posedge clk); #2;
      miss_valid = (cyc == 0) || intr;
      miss_line  = (cyc == 0) ? ln : ln ^ 26'h1;
      miss_word  = (cyc == 0) ? wd : wd + 4'd1;
      probe_line = pother ? ln ^ 26'h100 : ln;
      mreq_ready = rm[cyc % 16];
      mrsp_valid = (head < tail) && vm[cyc % 16];
      mrsp_data  = (head < tail) ? dfun(fq[head]) : '0;
      #5;
      if (cyc > 0 && miss_valid && miss_ready) intr_acc++;
      if (probe_stall !== (!pother && cyc >= 1)) pbad++;
      if (prev_wait && !(mreq_valid && mreq_addr == prev_addr)) hold_bad++;
      prev_wait = mreq_valid && !mreq_ready;
      prev_addr = mreq_addr;
      if (mreq_valid && mreq_ready) begin
        if (nreq < 16) begin got[nreq] = mreq_addr; fq[tail] = mreq_addr; tail++; end
        nreq++;
      end
      if (mrsp_valid && mrsp_ready) head++;
      if (arr_we) begin
        if (arr_index !== ln[IDX_W-1:0]) idx_bad++;
        mem[arr_word] = arr_wdata; nwr++; lastwr = cyc;
      end
      if (cpu_restart) begin nrst++; rdata = cpu_data; rcyc = cyc; end
      if (tag_we) begin
        ntag++; tcyc = cyc; wr_at_tag = nwr; done = 1;
        tag_ok = tag_valid && tag_index == ln[IDX_W-1:0] && tag_value == ln[LINE_W-1:IDX_W];
      end
      cyc++;
    end
    @(posedge clk); #2;
    miss_valid = 1'b0; mreq_ready = 1'b0; mrsp_valid = 1'b0;
    #5;
    chk(!busy && !tag_we && !probe_stall, "R5", "busy/tag after fill", {busy, tag_we, probe_stall}, 0);
    ord_ok = (nreq == 16); line_ok = 1; mem_ok = (nwr == 16) && (idx_bad == 0);
    for (int k = 1; k < 16; k++) if (got[k][OFS_W-1:0] != wd + 4'(k)) ord_ok = 0;
    for (int k = 0; k < 16; k++) if (got[k][MA_W-1:OFS_W] != ln) line_ok = 0;
    for (int k = 0; k < 16; k++) if (mem[k] != dfun({ln, 4'(k)})) mem_ok = 0;
    chk(got[0] == {ln, wd}, "R1", "first request", got[0], {ln, wd});
    chk(ord_ok, "R2", "wrapped order/count", nreq, 16);
    chk(line_ok, "R3", "request line field", got[15], {ln, wd - 4'd1});
    chk(rdata == dfun({ln, wd}), "R4", "restart data", rdata, dfun({ln, wd}));
    chk(rcyc >= 0 && rcyc < lastwr, "R4", "restart before last write", rcyc, lastwr);
    chk(nrst == 1, "R9", "restart pulse count", nrst, 1);
    chk(mem_ok, "R6", "array contents by position", nwr, 16);
    chk(ntag == 1 && tag_ok && tcyc == lastwr + 1, "R5", "tag update", tcyc, lastwr + 1);
    chk(wr_at_tag == 16, "R7", "writes before tag", wr_at_tag, 16);
    chk(pbad == 0, "R7", "probe stall cycles", pbad, 0);
    chk(intr_acc == 0, "R8", "miss accepted while busy", intr_acc, 0);
    chk(hold_bad == 0, "R10", "request held under back-pressure", hold_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #7;
    chk(!busy && miss_ready && !mreq_valid && !arr_we && !tag_we && !cpu_restart,
        "R11", "state in reset", {busy, miss_ready, mreq_valid, arr_we, tag_we, cpu_restart}, 6'b010000);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #6;
    chk(!busy && miss_ready && !mreq_valid && !tag_we && !cpu_restart,
        "R11", "state after reset", {busy, miss_ready, mreq_valid, tag_we, cpu_restart}, 5'b01000);
    for (int v = 0; v < NVEC; v++) begin
      run_fill(VEC[v][61:36], VEC[v][35:32], VEC[v][31:16], VEC[v][15:0],
               (v == 1 || v == 4), (v == 2));
    end
    // Corner: back-to-back fills of the same line with the critical word at offset 15 then 0.
    run_fill(26'h1234567, 4'd15, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    run_fill(26'h1234567, 4'd0, 16'h7777, 16'hEEEE, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule